// File: doc/BRIEF.md
# Bidirectional GPIO Port with Alternate Functions

This block is a 16-pin general-purpose I/O port of a larger chip. Each pin is set up through four registers: an output latch, a direction mask, a drive-mode mask that picks push-pull or open-drain, and an alternate-select mask. When a pin's alternate-select bit is set, a peripheral takes over that pin's output value and output enable.

For every pin the block produces a drive value and an output enable for the pad. It brings the pad level back in through a two-stage synchronizer. Peripherals see the synchronized levels directly.

Software reaches the registers over a simple single-cycle write strobe with an operation code. The code selects either a whole-word load or a set, clear or toggle of one bit named by an index. Read data is combinational from the register address. It returns live pin levels for input pins and the latched value for output pins.

Top module: `gpio_alt_port`

## Requirements
- R1: While `rst_n` is low and after its release, all four registers read as zero and every `pin_oe` bit is 0. This means every pin is an input, drives push-pull and has no alternate function.
- R2: A pin whose direction bit is 0 and whose alternate-select bit is 0 has its `pin_oe` bit at 0.
- R3: A general-purpose output pin in push-pull mode (direction 1, drive bit 0, alternate 0) has `pin_oe` = 1 and `pin_out` equal to its output-latch bit.
- R4: A pin with drive bit 1 (open-drain) asserts `pin_oe` only when its source value is 0, with `pin_out` = 0. A source value of 1 leaves the pin released (`pin_oe` = 0).
- R5: With `bus_wr` = 1 and `bus_op` = 0 (word load), the register at `bus_addr` is replaced by `bus_wdata` at the next clock edge. The addresses are 0 = output latch, 1 = direction, 2 = drive mode, 3 = alternate select.
- R6: With `bus_wr` = 1, `bus_op` 1 = set, 2 = clear and 3 = toggle change only bit `bus_bit` of the register at `bus_addr`, in one clock edge. No other bit of any register changes.
- R7: A pin with alternate-select bit 1 takes its source value from `per_out` and its enable from `per_oe`, and the drive mode of R4 still applies. Pins with the bit at 0 ignore `per_out` and `per_oe`.
- R8: Reading address 0 returns, per bit, the latched output value where the direction bit is 1 and the synchronized pin level where it is 0.
- R9: A change on `pin_in` appears on `per_in` and in the address-0 read after the second rising clock edge, and not after the first.
- R10: Reading addresses 1, 2 and 3 returns the stored direction, drive-mode and alternate-select registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one operation per cycle |
| bus_op | input | 2 | 0 word load, 1 set bit, 2 clear bit, 3 toggle bit |
| bus_addr | input | 2 | Register select for writes and reads |
| bus_bit | input | 4 | Bit index for set, clear and toggle |
| bus_wdata | input | 16 | Word-load data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_in | input | 16 | Asynchronous pad input levels |
| pin_out | output | 16 | Pad drive values |
| pin_oe | output | 16 | Pad output enables |
| per_out | input | 16 | Peripheral output values |
| per_oe | input | 16 | Peripheral output enables |
| per_in | output | 16 | Synchronized pad levels for peripherals |

## Verification
A corrupted register bit shows up at the ports at once, in the same cycle, because the drive mux is purely combinational from the registers. It appears on `pin_oe` or `pin_out` for the affected pin and in the next read of that address. A bit operation that touches the wrong index shows after the single write edge, in the readback of the target register. A shortened or lengthened synchronizer shows as the pin level arriving one edge early or late on `per_in` and in the level read. A wrong open-drain or alternate-select decision shows only on the pins whose mode bits are set, so the stimulus mixes modes within one word.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;

    // Register addresses; the level register at 0 reads back mixed pin data.
    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_DRIVE = 2'd2,
        SEL_ALT   = 2'd3
    } reg_sel_e;

    // Write operation codes.
    typedef enum logic [1:0] {
        OP_WORD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_FLIP = 2'd3
    } bit_op_e;

    localparam int NUM_REGS = 4;

endpackage

// File: rtl/gpio_alt_sync.sv
module gpio_alt_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(d)); // R9

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_chain_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> stage_q[s] == $past(stage_q[s-1])); // R9
        end
    endgenerate

endmodule

// File: rtl/gpio_alt_regs.sv
module gpio_alt_regs
    import gpio_alt_pkg::*;
#(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       op,
    input  logic [1:0]       addr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pin_sync,
    output logic [W-1:0]     level_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     drive_q,
    output logic [W-1:0]     alt_q,
    output logic [W-1:0]     rdata
);

    logic [NUM_REGS-1:0][W-1:0] regs_q;

    function automatic logic [W-1:0] apply_op(
        input logic [W-1:0]     cur,
        input bit_op_e          code,
        input logic [IDX_W-1:0] idx,
        input logic [W-1:0]     wd
    );
        logic [W-1:0] mask;
        logic [W-1:0] res;
        mask = {{(W-1){1'b0}}, 1'b1} << idx;
        unique case (code)
            OP_WORD: res = wd;
            OP_SET:  res = cur | mask;
            OP_CLR:  res = cur & ~mask;
            OP_FLIP: res = cur ^ mask;
        endcase
        return res;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr == r[1:0]) begin
                    regs_q[r] <= apply_op(regs_q[r], bit_op_e'(op), bit_idx, wdata);
                end
            end
        end
    end

    assign level_q = regs_q[SEL_LEVEL];
    assign dir_q   = regs_q[SEL_DIR];
    assign drive_q = regs_q[SEL_DRIVE];
    assign alt_q   = regs_q[SEL_ALT];

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_LEVEL: rdata = (dir_q & level_q) | (~dir_q & pin_sync);
            SEL_DIR:   rdata = dir_q;
            SEL_DRIVE: rdata = drive_q;
            SEL_ALT:   rdata = alt_q;
        endcase
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> regs_q == '0); // R1

    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op == OP_WORD && addr == SEL_DIR) |=> dir_q == $past(wdata)); // R5

    AST_BITOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op != OP_WORD) |=> $countones(regs_q ^ $past(regs_q)) <= 1); // R6

endmodule

// File: rtl/gpio_alt_drive.sv
module gpio_alt_drive #(
    parameter int W = 16
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] drive_q,
    input  logic [W-1:0] alt_q,
    input  logic [W-1:0] level_q,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            logic src_val;
            logic src_en;
            assign src_val    = alt_q[i] ? per_out[i] : level_q[i];
            assign src_en     = alt_q[i] ? per_oe[i]  : dir_q[i];
            // Open-drain pins only ever pull low.
            assign pin_oe[i]  = src_en & (~drive_q[i] | ~src_val);
            assign pin_out[i] = src_val & ~drive_q[i];
        end
    endgenerate

endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
    import gpio_alt_pkg::*;
#(
    parameter int PINS        = 16,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_op,
    input  logic [1:0]       bus_addr,
    input  logic [IDX_W-1:0] bus_bit,
    input  logic [PINS-1:0]  bus_wdata,
    output logic [PINS-1:0]  bus_rdata,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_oe,
    input  logic [PINS-1:0]  per_out,
    input  logic [PINS-1:0]  per_oe,
    output logic [PINS-1:0]  per_in
);

    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] level_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] drive_q;
    logic [PINS-1:0] alt_q;

    gpio_alt_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_alt_regs #(.W(PINS), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .op       (bus_op),
        .addr     (bus_addr),
        .bit_idx  (bus_bit),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .level_q  (level_q),
        .dir_q    (dir_q),
        .drive_q  (drive_q),
        .alt_q    (alt_q),
        .rdata    (bus_rdata)
    );

    gpio_alt_drive #(.W(PINS)) u_drive (
        .dir_q   (dir_q),
        .drive_q (drive_q),
        .alt_q   (alt_q),
        .level_q (level_q),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign per_in = pin_sync;

    AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (~dir_q & ~alt_q & pin_oe) == '0); // R2

    AST_PP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~alt_q & ~drive_q) & ((pin_out ^ level_q) | ~pin_oe)) == '0); // R3

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_q & pin_oe & pin_out) == '0); // R4

    AST_ALT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_q & ~drive_q) & (pin_oe ^ per_oe)) == '0); // R7

endmodule

// File: tb/sim_gpio_alt_port.sv
module sim_gpio_alt_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_op = '0;
    logic [1:0]  bus_addr = '0;
    logic [3:0]  bus_bit = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [15:0] per_out = '0;
    logic [15:0] per_oe = '0;
    logic [15:0] per_in;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_alt_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_op    (bus_op),
        .bus_addr  (bus_addr),
        .bus_bit   (bus_bit),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .per_out   (per_out),
        .per_oe    (per_oe),
        .per_in    (per_in)
    );

    // Vector: op(2) addr(2) bit(4) wdata(16) expected readback(16)
    localparam int NVEC = 10;
    localparam logic [39:0] VEC [NVEC] = '{
        {2'd0, 2'd1, 4'd0,  16'h00FF, 16'h00FF},
        {2'd0, 2'd0, 4'd0,  16'hA5A5, 16'h00A5},
        {2'd1, 2'd1, 4'd9,  16'h0000, 16'h02FF},
        {2'd2, 2'd1, 4'd0,  16'h0000, 16'h02FE},
        {2'd3, 2'd1, 4'd15, 16'h0000, 16'h82FE},
        {2'd3, 2'd1, 4'd15, 16'h0000, 16'h02FE},
        {2'd1, 2'd2, 4'd3,  16'h0000, 16'h0008},
        {2'd0, 2'd3, 4'd0,  16'h0F00, 16'h0F00},
        {2'd2, 2'd3, 4'd8,  16'h0000, 16'h0E00},
        {2'd1, 2'd0, 4'd1,  16'h0000, 16'h00A6}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] op, input logic [1:0] addr,
                             input logic [3:0] idx, input logic [15:0] wd);
        @(negedge clk);
        bus_op    = op;
        bus_addr  = addr;
        bus_bit   = idx;
        bus_wdata = wd;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [1:0] addr, input logic [15:0] exp);
        bus_addr = addr;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 oe in reset", pin_oe, 16'h0000);
        read_check("R1 dir in reset", 2'd1, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) read_check("R1 regs after reset", a[1:0], 16'h0000);
        check("R1 oe after reset", pin_oe, 16'h0000);

        // Table walk: R5 word loads, R6 bit ops, R8 level read, R10 readback
        for (int v = 0; v < NVEC; v++) begin
            bus_write(VEC[v][39:38], VEC[v][37:36], VEC[v][35:32], VEC[v][31:16]);
            if (VEC[v][39:38] != 2'd0)       read_check("R6 bit op", VEC[v][37:36], VEC[v][15:0]);
            else if (VEC[v][37:36] == 2'd0)  read_check("R8 level read", 2'd0, VEC[v][15:0]);
            else                             read_check("R5 R10 word load", VEC[v][37:36], VEC[v][15:0]);
        end

        // R3: push-pull outputs
        bus_write(2'd0, 2'd3, 4'd0, 16'h0000);
        bus_write(2'd0, 2'd2, 4'd0, 16'h0000);
        bus_write(2'd0, 2'd0, 4'd0, 16'h1234);
        bus_write(2'd0, 2'd1, 4'd0, 16'hFFFF);
        #1;
        check("R3 pp oe", pin_oe, 16'hFFFF);
        check("R3 pp out", pin_out, 16'h1234);

        // R4: open-drain
        bus_write(2'd0, 2'd2, 4'd0, 16'hFFFF);
        #1;
        check("R4 od oe", pin_oe, 16'hEDCB);
        check("R4 od out", pin_out, 16'h0000);

        // R2: inputs released
        bus_write(2'd0, 2'd1, 4'd0, 16'h0000);
        #1;
        check("R2 input hiz", pin_oe, 16'h0000);

        // R7: alternate override, push-pull then open-drain
        bus_write(2'd0, 2'd2, 4'd0, 16'h0000);
        bus_write(2'd0, 2'd0, 4'd0, 16'hFFFF);
        bus_write(2'd0, 2'd1, 4'd0, 16'hFF00);
        per_out = 16'hFFF0;
        per_oe  = 16'hFF3C;
        bus_write(2'd0, 2'd3, 4'd0, 16'h00FF);
        #1;
        check("R7 alt pp oe", pin_oe, 16'hFF3C);
        check("R7 alt pp out", pin_out, 16'hFFF0);
        per_oe = 16'h003C;
        #1;
        check("R7 unselected pins ignore per_oe", pin_oe, 16'hFF3C);
        bus_write(2'd0, 2'd2, 4'd0, 16'h00FF);
        #1;
        check("R7 alt od oe", pin_oe, 16'hFF0C);
        check("R7 alt od out", pin_out, 16'hFF00);

        // R9: synchronizer latency
        bus_write(2'd0, 2'd3, 4'd0, 16'h0000);
        bus_write(2'd0, 2'd2, 4'd0, 16'h0000);
        bus_write(2'd0, 2'd1, 4'd0, 16'h0000);
        bus_addr = 2'd0;
        pin_in = 16'hBEEF;
        @(negedge clk);
        check("R9 not after one edge", per_in, 16'h0000);
        read_check("R9 read after one edge", 2'd0, 16'h0000);
        @(negedge clk);
        check("R9 after two edges", per_in, 16'hBEEF);
        read_check("R9 read after two edges", 2'd0, 16'hBEEF);

        // R8: mixed level read
        bus_write(2'd0, 2'd0, 4'd0, 16'h1234);
        bus_write(2'd0, 2'd1, 4'd0, 16'h00FF);
        read_check("R8 mixed read", 2'd0, 16'hBE34);

        // R1: reset mid-run
        bus_write(2'd0, 2'd1, 4'd0, 16'hFFFF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset oe", pin_oe, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        read_check("R1 dir cleared", 2'd1, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule